// File: doc/BRIEF.md
# Continuous ADC Channel Sequencer with Threshold-Gated Interrupt

This block drives an external successive-approximation converter through a start/done handshake. It keeps the converter busy without software help. It picks the channel for each conversion and stores every returned sample in a per-channel result register. It then decides whether that sample should raise the conversion-complete interrupt. Setting the enable input starts the activity, and clearing it stops the activity.

Two continuous modes are offered. In select mode one channel is converted again and again. In scan mode the channels are swept in rising order from channel 0 to a chosen last channel, and the sweep then wraps back to channel 0. The interrupt is gated by a low-supply style comparison. The upper byte of a 10-bit sample is compared with an 8-bit threshold, in a direction set by a polarity input. In scan mode only the channel 0 sample takes part in that comparison. Samples from the other channels are stored but never raise the interrupt.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, `conv_start`, `irq` and `conv_ch` are 0 and every result register reads 0.
- R2: When `run_en` is seen high while the sequencer is idle, a one-cycle `conv_start` pulse appears one cycle later. In select mode it carries the selected channel, and in scan mode it carries channel 0.
- R3: While `run_en` stays high, the next `conv_start` is issued in the cycle right after the result of the previous conversion is stored. No `conv_start` is issued while a conversion is outstanding.
- R4: In select mode (`scan_mode`=0) every conversion uses the channel named by `ch_sel`.
- R5: Each accepted `conv_done` writes `conv_data` into the result register of the channel just converted, whatever the outcome of the comparison. The new value is visible one cycle after the strobe. Channel n sits at bits n*10 to n*10+9 of `results`.
- R6: The comparison uses `conv_data[9:2]` against `threshold`. With `pol_below`=0 it passes when that byte is greater than or equal to `threshold`. With `pol_below`=1 it passes when that byte is less than `threshold`. A passing comparison gives a one-cycle `irq` pulse in the same cycle in which the stored value first shows. A failing comparison gives no pulse.
- R7: In scan mode (`scan_mode`=1) channels are converted in the order 0, 1, ..., last. After the last channel the sequence continues at channel 0.
- R8: In scan mode only the channel 0 sample can raise `irq`. Samples from other channels never do, even when their comparison would pass.
- R9: A `ch_sel` value above 11 acts as 11, both as the select-mode channel and as the scan-mode last channel.
- R10: Clearing `run_en` while a conversion is outstanding discards that conversion. `conv_ch` returns to 0 in the next cycle, and the result registers are unchanged.
- R11: A `conv_done` strobe that arrives while the sequencer is idle is ignored. It raises no `irq`, no `conv_start`, and makes no result write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enable for continuous conversion |
| scan_mode | input | 1 | 0 = repeat one channel, 1 = sweep from channel 0 to last |
| ch_sel | input | 4 | Selected channel (select mode) or last channel (scan mode) |
| threshold | input | 8 | Comparison threshold for the sample's upper byte |
| pol_below | input | 1 | 0 = pass when byte >= threshold, 1 = pass when byte < threshold |
| conv_done | input | 1 | One-cycle strobe from the converter: sample ready |
| conv_data | input | 10 | Sample returned with `conv_done` |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_ch | output | 4 | Channel being converted |
| irq | output | 1 | Conversion-complete interrupt pulse |
| results | output | 120 | Per-channel result registers, channel n at bits n*10 +: 10 |

## Verification
The bench builds the block with its default parameters: twelve channels, 10-bit samples and an 8-bit threshold. The 4-bit channel select can therefore carry the values 12 to 15, so the clamp to channel 11 can be reached from the ports. With the 8-bit threshold, the equality boundary and the extreme thresholds 0x00 and 0xFF can be exercised in both polarities. A scan with last channel 3 can be run long enough to show the wrap back to channel 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef enum logic {
        SENSE_AT_OR_ABOVE = 1'b0,
        SENSE_BELOW       = 1'b1
    } cmp_sense_e;

endpackage

// File: rtl/adc_seq_chan_step.sv
module adc_seq_chan_step #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4
) (
    input  logic [CH_W-1:0] cur_ch,
    input  logic [CH_W-1:0] sel_raw,
    input  logic            scan,
    output logic [CH_W-1:0] first_ch,
    output logic [CH_W-1:0] next_ch
);
    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] last_ch;

    always_comb begin
        // clamp an out-of-range select to the highest channel
        last_ch = (sel_raw > TOP_CH) ? TOP_CH : sel_raw;
        if (scan) begin
            first_ch = '0;
            next_ch  = (cur_ch >= last_ch) ? '0 : cur_ch + CH_W'(1);
        end else begin
            first_ch = last_ch;
            next_ch  = last_ch;
        end
    end

endmodule

// File: rtl/adc_seq_thresh_cmp.sv
module adc_seq_thresh_cmp
    import adc_seq_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic [THR_W-1:0] sample_hi,
    input  logic [THR_W-1:0] threshold,
    input  logic             below,
    output logic             hit
);
    cmp_sense_e sense;

    always_comb begin
        sense = cmp_sense_e'(below);
        case (sense)
            SENSE_BELOW: hit = (sample_hi <  threshold);
            default:     hit = (sample_hi >= threshold);
        endcase
    end

endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
    parameter int NUM_CH = 12,
    parameter int RES_W  = 10,
    parameter int CH_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic [RES_W-1:0]        wr_data,
    output logic [NUM_CH*RES_W-1:0] res_flat
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
        logic [RES_W-1:0] ent_d;
        logic [RES_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_ch == CH_W'(g))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign res_flat[g*RES_W +: RES_W] = ent_q;
    end

endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int RES_W  = 10,
    parameter int THR_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic                    scan_mode,
    input  logic [CH_W-1:0]         ch_sel,
    input  logic [THR_W-1:0]        threshold,
    input  logic                    pol_below,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    output logic                    conv_start,
    output logic [CH_W-1:0]         conv_ch,
    output logic                    irq,
    output logic [NUM_CH*RES_W-1:0] results
);
    localparam int HI_LSB = RES_W - THR_W;

    typedef struct packed {
        seq_state_e      state;
        logic [CH_W-1:0] ch;
        logic            start;
        logic            irq;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [CH_W-1:0] first_ch;
    logic [CH_W-1:0] next_ch;
    logic            cmp_hit;
    logic            wr_en;

    adc_seq_chan_step #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_step (
        .cur_ch   (seq_q.ch),
        .sel_raw  (ch_sel),
        .scan     (scan_mode),
        .first_ch (first_ch),
        .next_ch  (next_ch)
    );

    adc_seq_thresh_cmp #(
        .THR_W (THR_W)
    ) u_cmp (
        .sample_hi (conv_data[RES_W-1:HI_LSB]),
        .threshold (threshold),
        .below     (pol_below),
        .hit       (cmp_hit)
    );

    adc_seq_result_bank #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .CH_W   (CH_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (seq_q.ch),
        .wr_data  (conv_data),
        .res_flat (results)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.irq   = 1'b0;
        wr_en       = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (run_en) begin
                    seq_d.state = ST_BUSY;
                    seq_d.ch    = first_ch;
                    seq_d.start = 1'b1;
                end
            end
            default: begin
                if (!run_en) begin
                    // abandon the outstanding conversion
                    seq_d.state = ST_IDLE;
                    seq_d.ch    = '0;
                end else if (conv_done && !seq_q.start) begin
                    wr_en       = 1'b1;
                    seq_d.irq   = cmp_hit && (!scan_mode || (seq_q.ch == '0));
                    seq_d.ch    = next_ch;
                    seq_d.start = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, ch: '0, start: 1'b0, irq: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start = seq_q.start;
    assign conv_ch    = seq_q.ch;
    assign irq        = seq_q.irq;

endmodule

// File: rtl/adc_sweep_seq_checker.sv
module adc_sweep_seq_checker #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            scan_mode,
    input logic            conv_done,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_ch,
    input logic            irq
);

    p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(run_en));

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_irq_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(conv_done));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_scan_irq_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(scan_mode)) |-> ($past(conv_ch) == '0));

    p_ch_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ch <= CH_W'(NUM_CH - 1));

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!irq && !conv_start && (conv_ch == '0)));

endmodule

bind adc_sweep_seq adc_sweep_seq_checker #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .scan_mode  (scan_mode),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .irq        (irq)
);

// File: tb/test_adc_sweep_seq.sv
module test_adc_sweep_seq;
    localparam int NUM_CH = 12;
    localparam int RES_W  = 10;
    localparam int THR_W  = 8;
    localparam int CH_W   = 4;
    localparam int LAT    = 3;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    run_en;
    logic                    scan_mode;
    logic [CH_W-1:0]         ch_sel;
    logic [THR_W-1:0]        threshold;
    logic                    pol_below;
    logic                    conv_done;
    logic [RES_W-1:0]        conv_data;
    logic                    conv_start;
    logic [CH_W-1:0]         conv_ch;
    logic                    irq;
    logic [NUM_CH*RES_W-1:0] results;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [3:0] sel;
        logic [7:0] thr;
        logic       pol;
        logic [9:0] data;
        logic       exp_irq;
    } vec_t;

    // select-mode comparison vectors (R6 boundaries, R9 clamp)
    localparam vec_t VECS [10] = '{
        '{4'd1,  8'h40, 1'b0, 10'h100, 1'b1},
        '{4'd1,  8'h40, 1'b0, 10'h0FF, 1'b0},
        '{4'd1,  8'h40, 1'b1, 10'h0FF, 1'b1},
        '{4'd1,  8'h40, 1'b1, 10'h100, 1'b0},
        '{4'd5,  8'h00, 1'b0, 10'h000, 1'b1},
        '{4'd5,  8'h00, 1'b1, 10'h3FF, 1'b0},
        '{4'd11, 8'hFF, 1'b0, 10'h3FF, 1'b1},
        '{4'd14, 8'hFF, 1'b1, 10'h3FB, 1'b1},
        '{4'd0,  8'h80, 1'b0, 10'h1FF, 1'b0},
        '{4'd0,  8'h80, 1'b0, 10'h203, 1'b1}
    };

    always #10 clk = ~clk;

    adc_sweep_seq i_adc_sweep_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .scan_mode  (scan_mode),
        .ch_sel     (ch_sel),
        .threshold  (threshold),
        .pol_below  (pol_below),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .irq        (irq),
        .results    (results)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [RES_W-1:0] res_of(input int ch);
        return results[ch*RES_W +: RES_W];
    endfunction

    task automatic wait_start(output int ch);
        ch = -1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (conv_start) begin
                ch = int'(conv_ch);
                return;
            end
        end
    endtask

    // converter model: idle for LAT cycles, then one done strobe
    task automatic finish_conv(input logic [RES_W-1:0] data, output bit quiet);
        quiet = 1'b1;
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            if (conv_start) quiet = 1'b0;
        end
        conv_done = 1'b1;
        conv_data = data;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int ch;
        int exp_ch;
        bit quiet;
        logic [RES_W-1:0] old;
        logic [RES_W-1:0] d;

        rst_n = 1'b0; run_en = 1'b0; scan_mode = 1'b0; ch_sel = '0;
        threshold = '0; pol_below = 1'b0; conv_done = 1'b0; conv_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 conv_start", 32'(conv_start), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 conv_ch", 32'(conv_ch), 0);
        check("R1 results", 32'(results == '0), 1);

        // R4 R5 R6 R9 vector walk in select mode
        foreach (VECS[i]) begin
            stop_run();
            scan_mode = 1'b0;
            ch_sel    = VECS[i].sel;
            threshold = VECS[i].thr;
            pol_below = VECS[i].pol;
            run_en    = 1'b1;
            wait_start(ch);
            exp_ch = (int'(VECS[i].sel) > NUM_CH - 1) ? NUM_CH - 1 : int'(VECS[i].sel);
            check("R4/R9 start channel", 32'(ch), 32'(exp_ch));
            finish_conv(VECS[i].data, quiet);
            check("R6 irq", 32'(irq), 32'(VECS[i].exp_irq));
            check("R5 stored result", 32'(res_of(exp_ch)), 32'(VECS[i].data));
        end

        // R2 R3 R4 back-to-back select conversions
        stop_run();
        scan_mode = 1'b0; ch_sel = 4'd3; threshold = 8'h00; pol_below = 1'b0;
        run_en = 1'b1;
        wait_start(ch);
        check("R2 first select channel", 32'(ch), 3);
        for (int k = 0; k < 3; k++) begin
            finish_conv(10'h011 + 10'(k), quiet);
            check("R3 no start while outstanding", 32'(quiet), 1);
            check("R3 next start follows store", 32'(conv_start), 1);
            check("R4 repeated channel", 32'(conv_ch), 3);
            check("R5 select store", 32'(res_of(3)), 32'(10'h011 + 10'(k)));
        end

        // R7 R8 scan 0..3 with wrap, threshold always passing
        stop_run();
        scan_mode = 1'b1; ch_sel = 4'd3; threshold = 8'h00; pol_below = 1'b0;
        run_en = 1'b1;
        wait_start(ch);
        check("R2 scan starts at 0", 32'(ch), 0);
        for (int k = 0; k < 6; k++) begin
            check("R7 scan order", 32'(conv_ch), 32'(k % 4));
            d = 10'h050 + 10'(k * 7);
            finish_conv(d, quiet);
            check("R8 irq only for channel 0", 32'(irq), 32'((k % 4) == 0));
            check("R7 scan store", 32'(res_of(k % 4)), 32'(d));
        end

        // R10 R11 abort during conversion, then stray done while idle
        stop_run();
        scan_mode = 1'b0; ch_sel = 4'd2; threshold = 8'h00; pol_below = 1'b0;
        run_en = 1'b1;
        wait_start(ch);
        old = res_of(2);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check("R10 channel back to 0", 32'(conv_ch), 0);
        conv_done = 1'b1; conv_data = 10'h3FF;
        @(negedge clk);
        conv_done = 1'b0;
        check("R11 idle done no irq", 32'(irq), 0);
        check("R11 idle done no start", 32'(conv_start), 0);
        check("R10 discarded result", 32'(res_of(2)), 32'(old));

        // R10 restart in scan at channel 0; R8 failing comparison on ch0
        scan_mode = 1'b1; ch_sel = 4'd2; threshold = 8'h10; pol_below = 1'b0;
        run_en = 1'b1;
        wait_start(ch);
        check("R10 restart at channel 0", 32'(ch), 0);
        finish_conv(10'h000, quiet);
        check("R8 ch0 below threshold no irq", 32'(irq), 0);
        check("R5 stored despite no irq", 32'(res_of(0)), 0);
        stop_run();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule